// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer

This block manages the receive storage of one bulk or interrupt OUT endpoint in a USB device controller. A packet-receive front end announces each OUT transaction with a start strobe, then delivers payload bytes with a byte strobe, and ends with either an end-of-packet strobe or an abort. At the start strobe the block decides whether to accept the transaction. It accepts only when the endpoint is not force-NAKed and a full maximum-size packet still fits. The ACK or NAK handshake comes out on the end-of-packet cycle. Bytes become readable only once the packet is complete.

The stored bytes are drained oldest first by exactly one of two consumers. One is a register-style CPU read strobe. The other is a streaming valid/ready port for a DMA engine. Two join inputs choose which consumer owns the endpoint, and asserting both is flagged as an error. The number of unread bytes is reported as a high byte and a low byte.

After a short packet or a zero-length packet, the block latches a force-NAK flag so the next transfer waits for software. A control input can disable this. The storage holds two maximum-size packets (128 bytes for a 64-byte packet limit), so one packet can drain while the next arrives.

Top module: `usb_out_ep_fifo`

## Requirements
- R1: On a start strobe the transaction is accepted when force-NAK is clear and (DEPTH - unread count) >= MAX_PKT, and refused otherwise. On the end-of-packet cycle of that transaction, exactly one of hs_ack (accepted) or hs_nak (refused) is high, for that one cycle only.
- R2: A refused transaction stores no bytes. A transaction that ends with rx_abort stores no bytes and gives no handshake. Payload bytes beyond MAX_PKT in one packet are dropped.
- R3: Bytes are read out in the order they were received, on both read interfaces.
- R4: The unread count, {remain_hi, remain_lo}, equals the number of committed unread bytes. It rises by the packet length in the cycle after end-of-packet and falls by one in the cycle after each read.
- R5: When cpu_join and dma_join are both high, join_err is high, dma_valid is low, no read takes place and cpu_rd_data is 0.
- R6: With only cpu_join high and data held, cpu_rd_data shows the oldest byte combinationally. A high cpu_rd consumes that byte at the clock edge.
- R7: A CPU read while the buffer is empty returns 0 and leaves the unread count unchanged.
- R8: With only dma_join high, dma_valid is high exactly when data is held, and a byte moves on each cycle where dma_valid and dma_ready are both high. dma_valid drops when the buffer empties and rises again on its own when a new packet is committed.
- R9: An accepted packet shorter than MAX_PKT, zero length included, sets force_nak in the cycle after its end-of-packet while dis_short_nak is low. A full-size packet does not set it.
- R10: While dis_short_nak is high, a short packet leaves force_nak clear.
- R11: While force_nak is set, every transaction is refused regardless of free space. A fnak_clr pulse clears force_nak.
- R12: While rst_n is low, the buffer is empty, force_nak is clear, the unread count is zero and dma_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sop | input | 1 | Start of an OUT transaction |
| rx_valid | input | 1 | Payload byte strobe |
| rx_data | input | 8 | Payload byte |
| rx_eop | input | 1 | End of packet, packet good |
| rx_abort | input | 1 | Packet aborted, discard |
| dis_short_nak | input | 1 | Disable force-NAK after short packet |
| fnak_clr | input | 1 | Clear force-NAK |
| cpu_join | input | 1 | CPU owns the read side |
| dma_join | input | 1 | DMA port owns the read side |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rd_data | output | 8 | Byte returned to the CPU |
| dma_valid | output | 1 | Stream byte available |
| dma_ready | input | 1 | Stream consumer ready |
| dma_data | output | 8 | Stream byte |
| hs_ack | output | 1 | ACK pulse on end-of-packet |
| hs_nak | output | 1 | NAK pulse on end-of-packet |
| force_nak | output | 1 | Force-NAK flag |
| join_err | output | 1 | Both read interfaces joined |
| remain_hi | output | 8 | Unread count, high byte |
| remain_lo | output | 8 | Unread count, low byte |

## Verification
The assertions rely on the packet interface behaving as a front end would:
- rx_sop comes only between transactions.
- Payload strobes come only between a start and its end.
- rx_eop and rx_abort never coincide with a byte strobe.

The bench respects these rules by driving every transaction through a single task that issues the start, the bytes and the ending in separate cycles. It also changes the join inputs only while no transaction is open, which keeps the handshake and force-NAK properties meaningful.

// File: rtl/usb_ofifo_pkg.sv
package usb_ofifo_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_TAKE = 2'd1,
    RX_DROP = 2'd2
  } rx_state_e;
endpackage

// File: rtl/usb_ofifo_rx.sv
module usb_ofifo_rx
  import usb_ofifo_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DEPTH   = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int LW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_sop,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_eop,
  input  logic          rx_abort,
  input  logic          dis_short_nak,
  input  logic          fnak_clr,
  input  logic [CW-1:0] used,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          commit,
  output logic [LW-1:0] commit_len,
  output logic          hs_ack,
  output logic          hs_nak,
  output logic          force_nak
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] PKT_CW  = CW'(MAX_PKT);
  localparam logic [LW-1:0] PKT_LW  = LW'(MAX_PKT);

  rx_state_e     state_q, state_d;
  logic [LW-1:0] len_q, len_d;
  logic [AW-1:0] base_q, base_d;
  logic          fnak_q, fnak_d;
  logic          room;

  // Free space is judged against committed data only; open packet space is reserved by this test.
  assign room = (DEPTH_C - used) >= PKT_CW;

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    base_d  = base_q;
    fnak_d  = fnak_q;
    wr_en   = 1'b0;
    commit  = 1'b0;
    hs_ack  = 1'b0;
    hs_nak  = 1'b0;
    if (fnak_clr) fnak_d = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (rx_sop) begin
          len_d   = '0;
          state_d = (room && !fnak_q) ? RX_TAKE : RX_DROP;
        end
      end
      RX_TAKE: begin
        if (rx_abort) begin
          state_d = RX_IDLE;
        end else if (rx_eop) begin
          hs_ack  = 1'b1;
          commit  = 1'b1;
          base_d  = base_q + AW'(len_q);
          state_d = RX_IDLE;
          if ((len_q < PKT_LW) && !dis_short_nak) fnak_d = 1'b1;
        end else if (rx_valid && (len_q < PKT_LW)) begin
          wr_en = 1'b1;
          len_d = len_q + LW'(1);
        end
      end
      RX_DROP: begin
        if (rx_abort) begin
          state_d = RX_IDLE;
        end else if (rx_eop) begin
          hs_nak  = 1'b1;
          state_d = RX_IDLE;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      len_q   <= '0;
      base_q  <= '0;
      fnak_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      base_q  <= base_d;
      fnak_q  <= fnak_d;
    end
  end

  assign wr_addr    = base_q + AW'(len_q);
  assign wr_data    = rx_data;
  assign commit_len = len_q;
  assign force_nak  = fnak_q;
endmodule

// File: rtl/usb_ofifo_mem.sv
module usb_ofifo_mem #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/usb_ofifo_rd.sv
module usb_ofifo_rd #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_join,
  input  logic          dma_join,
  input  logic          cpu_rd,
  input  logic          dma_ready,
  input  logic [CW-1:0] used,
  input  logic [7:0]    mem_data,
  output logic [AW-1:0] rd_addr,
  output logic          pop,
  output logic [7:0]    cpu_rd_data,
  output logic          dma_valid,
  output logic [7:0]    dma_data,
  output logic          join_err
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic          held, cpu_own, dma_own, cpu_pop, dma_pop;

  assign held     = (used != '0);
  assign cpu_own  = cpu_join && !dma_join;
  assign dma_own  = dma_join && !cpu_join;
  assign join_err = cpu_join && dma_join;

  assign cpu_pop   = cpu_own && cpu_rd && held;
  assign dma_valid = dma_own && held;
  assign dma_pop   = dma_valid && dma_ready;
  assign pop       = cpu_pop || dma_pop;

  assign cpu_rd_data = (cpu_own && held) ? mem_data : 8'h00;
  assign dma_data    = dma_valid ? mem_data : 8'h00;

  always_comb begin
    ptr_d = ptr_q;
    if (pop) ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign rd_addr = ptr_q;
endmodule

// File: rtl/usb_out_ep_fifo.sv
module usb_out_ep_fifo #(
  parameter int MAX_PKT = 64,
  parameter int DEPTH   = 2 * MAX_PKT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_sop,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_eop,
  input  logic       rx_abort,
  input  logic       dis_short_nak,
  input  logic       fnak_clr,
  input  logic       cpu_join,
  input  logic       dma_join,
  input  logic       cpu_rd,
  output logic [7:0] cpu_rd_data,
  output logic       dma_valid,
  input  logic       dma_ready,
  output logic [7:0] dma_data,
  output logic       hs_ack,
  output logic       hs_nak,
  output logic       force_nak,
  output logic       join_err,
  output logic [7:0] remain_hi,
  output logic [7:0] remain_lo
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = $clog2(MAX_PKT + 1);

  logic          wr_en, commit, pop;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, mem_data;
  logic [LW-1:0] commit_len;
  logic [CW-1:0] used_q, used_d;
  logic [15:0]   remain_w;

  usb_ofifo_rx #(.MAX_PKT(MAX_PKT), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_sop(rx_sop), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_eop(rx_eop), .rx_abort(rx_abort),
    .dis_short_nak(dis_short_nak), .fnak_clr(fnak_clr),
    .used(used_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_len(commit_len),
    .hs_ack(hs_ack), .hs_nak(hs_nak), .force_nak(force_nak)
  );

  usb_ofifo_mem #(.DEPTH(DEPTH), .DW(8)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(mem_data)
  );

  usb_ofifo_rd #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .cpu_join(cpu_join), .dma_join(dma_join),
    .cpu_rd(cpu_rd), .dma_ready(dma_ready),
    .used(used_q), .mem_data(mem_data),
    .rd_addr(rd_addr), .pop(pop),
    .cpu_rd_data(cpu_rd_data), .dma_valid(dma_valid), .dma_data(dma_data),
    .join_err(join_err)
  );

  // Committed-byte count: one packet may land and one byte leave in the same cycle.
  always_comb begin
    used_d = used_q;
    if (commit) used_d = used_d + CW'(commit_len);
    if (pop)    used_d = used_d - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end

  assign remain_w  = 16'(used_q);
  assign remain_hi = remain_w[15:8];
  assign remain_lo = remain_w[7:0];
endmodule

// File: rtl/usb_out_ep_fifo_chk.sv
module usb_out_ep_fifo_chk #(
  parameter int MAX_PKT = 64,
  parameter int DEPTH   = 128,
  localparam int LW = $clog2(MAX_PKT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_eop,
  input logic          hs_ack,
  input logic          hs_nak,
  input logic          cpu_join,
  input logic          dma_join,
  input logic          cpu_rd,
  input logic [7:0]    cpu_rd_data,
  input logic          dma_valid,
  input logic          join_err,
  input logic          force_nak,
  input logic          dis_short_nak,
  input logic [15:0]   remain,
  input logic [LW-1:0] commit_len
);
  localparam logic [LW-1:0] PKT_LW  = LW'(MAX_PKT);
  localparam logic [15:0]   DEPTH_W = 16'(DEPTH);

  assert_hs_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_ack && hs_nak));
  assert_hs_on_eop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_ack || hs_nak) |-> rx_eop);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= DEPTH_W);
  assert_join_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_join && dma_join) |-> (join_err && !dma_valid));
  assert_dummy_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && remain == 16'd0) |-> cpu_rd_data == 8'h00);
  assert_dummy_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && remain == 16'd0 && !hs_ack) |=> remain == 16'd0);
  assert_dma_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid |-> remain != 16'd0);
  assert_short_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_ack && commit_len < PKT_LW && !dis_short_nak) |=> force_nak);
  assert_short_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_short_nak && !force_nak) |=> !force_nak);
  assert_fnak_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> !force_nak);
endmodule

bind usb_out_ep_fifo usb_out_ep_fifo_chk #(.MAX_PKT(MAX_PKT), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_eop(rx_eop), .hs_ack(hs_ack), .hs_nak(hs_nak),
  .cpu_join(cpu_join), .dma_join(dma_join), .cpu_rd(cpu_rd),
  .cpu_rd_data(cpu_rd_data), .dma_valid(dma_valid), .join_err(join_err),
  .force_nak(force_nak), .dis_short_nak(dis_short_nak),
  .remain({remain_hi, remain_lo}), .commit_len(commit_len)
);

// File: tb/usb_out_ep_fifo_test.sv
`timescale 1ns/1ps
module usb_out_ep_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_sop, rx_valid, rx_eop, rx_abort, dis_short_nak, fnak_clr;
  logic [7:0] rx_data;
  logic       cpu_join, dma_join, cpu_rd, dma_ready;
  logic [7:0] cpu_rd_data, dma_data, remain_hi, remain_lo;
  logic       dma_valid, hs_ack, hs_nak, force_nak, join_err;

  int   checks = 0;
  int   errors = 0;
  int   rdy_mode = 0;
  int   cyc = 0;
  logic [7:0] q[$];

  always #2.5 clk = ~clk;

  usb_out_ep_fifo uut (
    .clk(clk), .rst_n(rst_n), .rx_sop(rx_sop), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_eop(rx_eop), .rx_abort(rx_abort), .dis_short_nak(dis_short_nak), .fnak_clr(fnak_clr),
    .cpu_join(cpu_join), .dma_join(dma_join), .cpu_rd(cpu_rd), .cpu_rd_data(cpu_rd_data),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_data(dma_data),
    .hs_ack(hs_ack), .hs_nak(hs_nak), .force_nak(force_nak), .join_err(join_err),
    .remain_hi(remain_hi), .remain_lo(remain_lo)
  );

  function automatic int remain();
    return int'({remain_hi, remain_lo});
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Ready pattern for the stream consumer
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    dma_ready = (rdy_mode == 1) || (rdy_mode == 2 && (cyc % 3) != 0);
  end

  // Stream monitor: pops expected bytes as transfers happen
  always @(negedge clk) begin
    if (rst_n && dma_valid && dma_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R8", "stream byte with nothing expected", int'(dma_data), -1);
      end else begin
        logic [7:0] e;
        e = q.pop_front();
        check(dma_data == e, "R3", "stream byte order", int'(dma_data), int'(e));
      end
    end
  end

  // Driver: one whole transaction, pushes expected bytes when an ACK is expected
  task automatic send_pkt(input int n, input int seed, input bit exp_ack);
    rx_sop = 1'b1;
    tick();
    rx_sop = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_data  = 8'(seed + i);
      if (exp_ack) q.push_back(8'(seed + i));
      tick();
    end
    rx_valid = 1'b0;
    rx_eop = 1'b1;
    @(negedge clk);
    check(hs_ack == exp_ack, "R1", "ack pulse on eop", int'(hs_ack), int'(exp_ack));
    check(hs_nak == !exp_ack, "R1", "nak pulse on eop", int'(hs_nak), int'(!exp_ack));
    tick();
    rx_eop = 1'b0;
    @(negedge clk);
    check(!hs_ack && !hs_nak, "R1", "handshake lasts one cycle", int'(hs_ack | hs_nak), 0);
    tick();
  endtask

  task automatic cpu_read();
    cpu_rd = 1'b1;
    @(negedge clk);
    if (q.size() == 0) begin
      check(cpu_rd_data == 8'h00, "R7", "dummy read data", int'(cpu_rd_data), 0);
    end else begin
      logic [7:0] e;
      e = q.pop_front();
      check(cpu_rd_data == e, "R6", "cpu byte order R3", int'(cpu_rd_data), int'(e));
    end
    tick();
    cpu_rd = 1'b0;
  endtask

  task automatic wait_drain();
    int n = 0;
    while (q.size() != 0 && n < 2000) begin
      tick();
      n++;
    end
    tick();
    tick();
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    rx_sop = 0; rx_valid = 0; rx_data = 0; rx_eop = 0; rx_abort = 0;
    dis_short_nak = 0; fnak_clr = 0; cpu_join = 0; dma_join = 0; cpu_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(remain() == 0, "R12", "count in reset", remain(), 0);
    check(!force_nak && !dma_valid, "R12", "flags in reset",
          int'({force_nak, dma_valid}), 0);
    tick();
    rst_n = 1'b1;
    tick();

    // Two full packets fill the buffer; a third is refused
    send_pkt(64, 8'h10, 1'b1);
    check(remain() == 64, "R4", "count after first packet", remain(), 64);
    check(!force_nak, "R9", "full packet leaves force-NAK clear", int'(force_nak), 0);
    send_pkt(64, 8'h50, 1'b1);
    check(remain() == 128, "R4", "count after second packet", remain(), 128);
    send_pkt(64, 8'h90, 1'b0);
    check(remain() == 128, "R2", "refused packet stores nothing", remain(), 128);

    // CPU drains ten bytes in order
    cpu_join = 1'b1;
    for (int i = 0; i < 10; i++) cpu_read();
    @(negedge clk);
    check(remain() == 118, "R4", "count after cpu reads", remain(), 118);
    tick();

    // Both joined: error, no transfer
    dma_join = 1'b1;
    rdy_mode = 1;
    cpu_rd = 1'b1;
    @(negedge clk);
    check(join_err && !dma_valid, "R5", "double join blocks stream",
          int'({join_err, dma_valid}), 2);
    check(cpu_rd_data == 8'h00, "R5", "double join cpu data", int'(cpu_rd_data), 0);
    tick();
    cpu_rd = 1'b0;
    @(negedge clk);
    check(remain() == 118, "R5", "double join count unchanged", remain(), 118);
    tick();

    // Stream drains the rest with a stuttering consumer
    cpu_join = 1'b0;
    rdy_mode = 2;
    wait_drain();
    @(negedge clk);
    check(!dma_valid && remain() == 0, "R8", "stream pauses when empty",
          int'(dma_valid), 0);
    tick();

    // New short packet: stream resumes by itself, force-NAK latches
    send_pkt(20, 8'h20, 1'b1);
    check(force_nak, "R9", "short packet sets force-NAK", int'(force_nak), 1);
    wait_drain();
    check(q.size() == 0, "R8", "stream resumed and drained", q.size(), 0);
    send_pkt(64, 8'h30, 1'b0);
    check(remain() == 0, "R11", "force-NAK refuses with room", remain(), 0);
    fnak_clr = 1'b1;
    tick();
    fnak_clr = 1'b0;
    @(negedge clk);
    check(!force_nak, "R11", "clear pulse drops force-NAK", int'(force_nak), 0);
    tick();
    send_pkt(64, 8'h40, 1'b1);
    wait_drain();

    // Zero-length packet
    send_pkt(0, 0, 1'b1);
    check(force_nak, "R9", "zero-length sets force-NAK", int'(force_nak), 1);
    check(remain() == 0, "R4", "zero-length adds nothing", remain(), 0);
    fnak_clr = 1'b1;
    tick();
    fnak_clr = 1'b0;

    // Auto-NAK disabled
    dis_short_nak = 1'b1;
    send_pkt(7, 8'h60, 1'b1);
    check(!force_nak, "R10", "disabled auto-NAK stays clear", int'(force_nak), 0);
    wait_drain();
    dis_short_nak = 1'b0;
    dma_join = 1'b0;
    rdy_mode = 0;
    tick();

    // Aborted packet is discarded with no handshake
    rx_sop = 1'b1;
    tick();
    rx_sop = 1'b0;
    for (int i = 0; i < 5; i++) begin
      rx_valid = 1'b1;
      rx_data  = 8'(8'hE0 + i);
      tick();
    end
    rx_valid = 1'b0;
    rx_abort = 1'b1;
    @(negedge clk);
    check(!hs_ack && !hs_nak, "R2", "abort gives no handshake",
          int'({hs_ack, hs_nak}), 0);
    tick();
    rx_abort = 1'b0;
    @(negedge clk);
    check(remain() == 0, "R2", "abort stores nothing", remain(), 0);
    tick();

    // CPU reads the next packet, then a dummy read on empty
    send_pkt(3, 8'hA0, 1'b1);
    cpu_join = 1'b1;
    for (int i = 0; i < 3; i++) cpu_read();
    cpu_read();
    @(negedge clk);
    check(remain() == 0, "R7", "dummy read keeps count", remain(), 0);
    tick();

    finish_run();
  end
endmodule